// File: doc/BRIEF.md
# Majority-Gate Bit-Serial SIMD Row Engine

This block is a digital model of one memory subarray: a bank of equal-width rows, plus a sequencer that does bit-serial arithmetic on those rows. Every column is an independent SIMD lane. An operand of width w occupies w consecutive rows starting at a base row, with its least significant bit in the base row. The sequencer uses only three row-level micro-ops. The first is a row copy. The second is a two-row activation that writes the inverse of one row into another. The third is a three-row activation that leaves the column-wise majority of the three rows in all three of them. It builds AND, OR and addition from these micro-ops alone.

The host loads operands through a simple row write port and reads results through a combinational row read port. It starts an operation by giving an opcode, two operand base rows, a result base row and a bit width. The top rows of the array are reserved. Two of them are hardwired constant rows (all zeros and all ones) that act as control inputs to the majority gate. One holds the running carry, and four are scratch rows. A three-row activation destroys its inputs, so operands and constants are always copied into scratch rows first. A logic bit takes 5 micro-ops and an addition bit takes 14, at one micro-op per clock.

Top module: `mbs_engine`

## Requirements
- R1: After synchronous reset, busy is low, every storage row reads as zero, row NUM_ROWS-1 reads all zeros and row NUM_ROWS-2 reads all ones.
- R2: While idle, a host write with wr_en high stores wr_data into any user row (index below NUM_ROWS-7) at the clock edge, and rd_data always shows the row selected by rd_row in the same cycle.
- R3: Host writes to any reserved row (index NUM_ROWS-7 or above) and host writes while busy have no effect, and the two constant rows never change.
- R4: Opcode 0 (AND) writes, for every lane and every bit k below the width, A[k] AND B[k] into result row d_base+k.
- R5: Opcode 1 (OR) writes, for every lane and every bit k below the width, A[k] OR B[k] into result row d_base+k.
- R6: Opcode 2 (ADD) writes (A + B) modulo 2^w in each lane independently, with the carry rippling from the least significant row upward, starting from a carry of zero.
- R7: The width is width_m1+1, from 1 to 16. Result rows at d_base+w and above are left unchanged.
- R8: Busy rises at the clock edge that accepts a start and stays high for exactly 5*w cycles for AND and OR and 14*w cycles for ADD. It falls at the edge that writes the last micro-op.
- R9: A start pulse while busy is ignored. The running operation keeps its opcode, bases, width and length.
- R10: Operand rows outside the result range are unchanged by an operation. Three-row activations only ever target scratch rows.
- R11: A result base equal to operand A's base (in-place update) still gives the correct sum.
- R12: A start with opcode 3 is ignored, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation when idle |
| op_i | input | 2 | 0 AND, 1 OR, 2 ADD, 3 rejected |
| a_base | input | ROW_BITS | First row of operand A |
| b_base | input | ROW_BITS | First row of operand B |
| d_base | input | ROW_BITS | First row of the result |
| width_m1 | input | WB | Bit width minus one |
| busy | output | 1 | High while micro-ops run |
| wr_en | input | 1 | Host row write strobe |
| wr_row | input | ROW_BITS | Host write row index |
| wr_data | input | COLS | Host write row data |
| rd_row | input | ROW_BITS | Host read row index |
| rd_data | output | COLS | Contents of the selected row |

## Verification
The bench uses the default build: 64 columns, 64 rows and a maximum width of 16. This gives 64 lanes to check in parallel and room for three disjoint 16-row fields plus sentinel rows. Lane 0 is set to all ones plus one so that a carry ripples through the full width. The runs cover the narrowest width (1), the widest (16) and an in-place sum of 12 bits. A start and a host write are injected in the middle of a run to show that neither disturbs it.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int IDX_W = 8;
    typedef logic [IDX_W-1:0] row_idx_t;

    typedef enum logic [1:0] {
        OP_AND = 2'd0,
        OP_OR  = 2'd1,
        OP_ADD = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        UK_NOP    = 2'd0,
        UK_COPY   = 2'd1,
        UK_NOT    = 2'd2,
        UK_TRIPLE = 2'd3
    } uop_kind_e;

    // COPY: r1 <= r0 ; NOT: r1 <= ~r0 ; TRIPLE: r0,r1,r2 <= maj(r0,r1,r2)
    typedef struct packed {
        uop_kind_e kind;
        row_idx_t  r0;
        row_idx_t  r1;
        row_idx_t  r2;
    } uop_t;

    // reserved slots counted down from the top row
    localparam int SLOT_ZERO  = 0;
    localparam int SLOT_ONE   = 1;
    localparam int SLOT_CARRY = 2;
    localparam int SLOT_T0    = 3;
    localparam int SLOT_T1    = 4;
    localparam int SLOT_T2    = 5;
    localparam int SLOT_T3    = 6;
    localparam int RSV_ROWS   = 7;

    function automatic row_idx_t rsv_row(int num_rows, int slot);
        return row_idx_t'(num_rows - 1 - slot);
    endfunction

    function automatic logic [3:0] last_step(op_e op);
        return (op == OP_ADD) ? 4'd13 : 4'd4;
    endfunction

endpackage

// File: rtl/mbs_seq.sv
module mbs_seq
    import mbs_pkg::*;
#(
    parameter int ROW_BITS = 6,
    parameter int WB       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          op_i,
    input  logic [ROW_BITS-1:0] a_base,
    input  logic [ROW_BITS-1:0] b_base,
    input  logic [ROW_BITS-1:0] d_base,
    input  logic [WB-1:0]       width_m1,
    output logic                busy_q,
    output op_e                 op_q,
    output logic [ROW_BITS-1:0] a_q,
    output logic [ROW_BITS-1:0] b_q,
    output logic [ROW_BITS-1:0] d_q,
    output logic [WB-1:0]       bit_q,
    output logic [3:0]          step_q
);

    logic [WB-1:0] wl_q;
    logic          accept;

    assign accept = !busy_q && start && (op_e'(op_i) != OP_RSV);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            op_q   <= OP_AND;
            a_q    <= '0;
            b_q    <= '0;
            d_q    <= '0;
            wl_q   <= '0;
            bit_q  <= '0;
            step_q <= '0;
        end else if (!busy_q) begin
            if (accept) begin
                busy_q <= 1'b1;
                op_q   <= op_e'(op_i);
                a_q    <= a_base;
                b_q    <= b_base;
                d_q    <= d_base;
                wl_q   <= width_m1;
                bit_q  <= '0;
                step_q <= '0;
            end
        end else if (step_q == last_step(op_q)) begin
            step_q <= '0;
            if (bit_q == wl_q) busy_q <= 1'b0;
            else               bit_q  <= bit_q + 1'b1;
        end else begin
            step_q <= step_q + 4'd1;
        end
    end

    // run-length counter used only by the length check
    logic [9:0] len_cnt;
    always_ff @(posedge clk) begin
        if (rst)          len_cnt <= '0;
        else if (accept)  len_cnt <= '0;
        else if (busy_q)  len_cnt <= len_cnt + 10'd1;
    end

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (int'(len_cnt) == (int'(wl_q) + 1) * (int'(last_step(op_q)) + 1))); // R8

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start) |=> ($stable(op_q) && $stable(wl_q) && $stable(d_q))); // R9

    AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (bit_q <= wl_q)); // R7

    AST_RESERVED_OP: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && start && op_i == 2'd3) |=> !busy_q); // R12

endmodule

// File: rtl/mbs_uop_gen.sv
module mbs_uop_gen
    import mbs_pkg::*;
#(
    parameter int NUM_ROWS = 64,
    parameter int ROW_BITS = 6,
    parameter int WB       = 4
) (
    input  logic                busy,
    input  op_e                 op,
    input  logic [ROW_BITS-1:0] a_q,
    input  logic [ROW_BITS-1:0] b_q,
    input  logic [ROW_BITS-1:0] d_q,
    input  logic [WB-1:0]       bit_q,
    input  logic [3:0]          step_q,
    output uop_t                uop
);

    localparam row_idx_t K0 = rsv_row(NUM_ROWS, SLOT_ZERO);
    localparam row_idx_t K1 = rsv_row(NUM_ROWS, SLOT_ONE);
    localparam row_idx_t CY = rsv_row(NUM_ROWS, SLOT_CARRY);
    localparam row_idx_t T0 = rsv_row(NUM_ROWS, SLOT_T0);
    localparam row_idx_t T1 = rsv_row(NUM_ROWS, SLOT_T1);
    localparam row_idx_t T2 = rsv_row(NUM_ROWS, SLOT_T2);
    localparam row_idx_t T3 = rsv_row(NUM_ROWS, SLOT_T3);

    row_idx_t ra, rb, rd;
    assign ra = row_idx_t'(ROW_BITS'(a_q + ROW_BITS'(bit_q)));
    assign rb = row_idx_t'(ROW_BITS'(b_q + ROW_BITS'(bit_q)));
    assign rd = row_idx_t'(ROW_BITS'(d_q + ROW_BITS'(bit_q)));

    function automatic uop_t mk(uop_kind_e k, row_idx_t x, row_idx_t y, row_idx_t z);
        uop_t u;
        u.kind = k; u.r0 = x; u.r1 = y; u.r2 = z;
        return u;
    endfunction

    always_comb begin
        uop = mk(UK_NOP, '0, '0, '0);
        if (busy) begin
            if (op == OP_ADD) begin
                case (step_q)
                    4'd0:  uop = mk(UK_COPY,   (bit_q == '0) ? K0 : CY, CY, '0);
                    4'd1:  uop = mk(UK_COPY,   ra, T0, '0);
                    4'd2:  uop = mk(UK_COPY,   rb, T1, '0);
                    4'd3:  uop = mk(UK_NOT,    CY, T2, '0);
                    4'd4:  uop = mk(UK_TRIPLE, T0, T1, T2);  // maj(a,b,~c)
                    4'd5:  uop = mk(UK_COPY,   ra, T1, '0);
                    4'd6:  uop = mk(UK_COPY,   rb, T2, '0);
                    4'd7:  uop = mk(UK_COPY,   CY, T3, '0);
                    4'd8:  uop = mk(UK_TRIPLE, T1, T2, T3);  // carry out
                    4'd9:  uop = mk(UK_NOT,    T1, T2, '0);
                    4'd10: uop = mk(UK_COPY,   CY, T3, '0);
                    4'd11: uop = mk(UK_TRIPLE, T0, T2, T3);  // sum
                    4'd12: uop = mk(UK_COPY,   T0, rd, '0);
                    4'd13: uop = mk(UK_COPY,   T1, CY, '0);
                    default: uop = mk(UK_NOP, '0, '0, '0);
                endcase
            end else begin
                case (step_q)
                    4'd0: uop = mk(UK_COPY,   ra, T0, '0);
                    4'd1: uop = mk(UK_COPY,   rb, T1, '0);
                    4'd2: uop = mk(UK_COPY,   (op == OP_AND) ? K0 : K1, T2, '0);
                    4'd3: uop = mk(UK_TRIPLE, T0, T1, T2);
                    4'd4: uop = mk(UK_COPY,   T0, rd, '0);
                    default: uop = mk(UK_NOP, '0, '0, '0);
                endcase
            end
        end
    end

endmodule

// File: rtl/mbs_rows.sv
module mbs_rows
    import mbs_pkg::*;
#(
    parameter int NUM_ROWS = 64,
    parameter int COLS     = 64,
    parameter int ROW_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  uop_t                uop,
    input  logic                host_we,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [COLS-1:0]     wr_data,
    input  logic [ROW_BITS-1:0] rd_row,
    output logic [COLS-1:0]     rd_data
);

    localparam int       USER_ROWS = NUM_ROWS - RSV_ROWS;
    localparam row_idx_t K0 = rsv_row(NUM_ROWS, SLOT_ZERO);
    localparam row_idx_t K1 = rsv_row(NUM_ROWS, SLOT_ONE);
    localparam row_idx_t TLO = rsv_row(NUM_ROWS, SLOT_T3);
    localparam row_idx_t THI = rsv_row(NUM_ROWS, SLOT_T0);

    logic [COLS-1:0] mem [NUM_ROWS];

    function automatic logic [COLS-1:0] fetch(row_idx_t i);
        if (i == K0)                    return '0;
        if (i == K1)                    return '1;
        if (int'(i) >= NUM_ROWS)        return '0;
        return mem[i[ROW_BITS-1:0]];
    endfunction

    logic [COLS-1:0] v0, v1, v2, vmaj;
    always_comb begin
        v0   = fetch(uop.r0);
        v1   = fetch(uop.r1);
        v2   = fetch(uop.r2);
        vmaj = (v0 & v1) | (v0 & v2) | (v1 & v2);
    end

    assign rd_data = fetch(row_idx_t'(rd_row));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_ROWS; r++) mem[r] <= '0;
        end else begin
            case (uop.kind)
                UK_COPY:   mem[uop.r1[ROW_BITS-1:0]] <= v0;
                UK_NOT:    mem[uop.r1[ROW_BITS-1:0]] <= ~v0;
                UK_TRIPLE: begin
                    mem[uop.r0[ROW_BITS-1:0]] <= vmaj;
                    mem[uop.r1[ROW_BITS-1:0]] <= vmaj;
                    mem[uop.r2[ROW_BITS-1:0]] <= vmaj;
                end
                default: begin
                    if (host_we && int'(wr_row) < USER_ROWS) mem[wr_row] <= wr_data;
                end
            endcase
        end
    end

    AST_NO_CONST_TARGET: assert property (@(posedge clk) disable iff (rst)
        (uop.kind != UK_NOP) |-> (uop.r1 != K0 && uop.r1 != K1)); // R3

    AST_TRIPLE_ON_SCRATCH: assert property (@(posedge clk) disable iff (rst)
        (uop.kind == UK_TRIPLE) |-> (uop.r0 >= TLO && uop.r0 <= THI &&
                                     uop.r1 >= TLO && uop.r1 <= THI &&
                                     uop.r2 >= TLO && uop.r2 <= THI)); // R10

endmodule

// File: rtl/mbs_engine.sv
module mbs_engine
    import mbs_pkg::*;
#(
    parameter int NUM_ROWS = 64,
    parameter int COLS     = 64,
    parameter int MAX_W    = 16,
    localparam int ROW_BITS = $clog2(NUM_ROWS),
    localparam int WB       = $clog2(MAX_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          op_i,
    input  logic [ROW_BITS-1:0] a_base,
    input  logic [ROW_BITS-1:0] b_base,
    input  logic [ROW_BITS-1:0] d_base,
    input  logic [WB-1:0]       width_m1,
    output logic                busy,
    input  logic                wr_en,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [COLS-1:0]     wr_data,
    input  logic [ROW_BITS-1:0] rd_row,
    output logic [COLS-1:0]     rd_data
);

    op_e                 op_q;
    logic [ROW_BITS-1:0] a_q, b_q, d_q;
    logic [WB-1:0]       bit_q;
    logic [3:0]          step_q;
    uop_t                uop;

    mbs_seq #(.ROW_BITS(ROW_BITS), .WB(WB)) u_seq (
        .clk(clk), .rst(rst), .start(start), .op_i(op_i),
        .a_base(a_base), .b_base(b_base), .d_base(d_base), .width_m1(width_m1),
        .busy_q(busy), .op_q(op_q), .a_q(a_q), .b_q(b_q), .d_q(d_q),
        .bit_q(bit_q), .step_q(step_q)
    );

    mbs_uop_gen #(.NUM_ROWS(NUM_ROWS), .ROW_BITS(ROW_BITS), .WB(WB)) u_gen (
        .busy(busy), .op(op_q), .a_q(a_q), .b_q(b_q), .d_q(d_q),
        .bit_q(bit_q), .step_q(step_q), .uop(uop)
    );

    mbs_rows #(.NUM_ROWS(NUM_ROWS), .COLS(COLS), .ROW_BITS(ROW_BITS)) u_rows (
        .clk(clk), .rst(rst), .uop(uop), .host_we(wr_en && !busy),
        .wr_row(wr_row), .wr_data(wr_data), .rd_row(rd_row), .rd_data(rd_data)
    );

endmodule

// File: tb/mbs_engine_tb.sv
module mbs_engine_tb;

    localparam int COLS = 64;
    localparam int NROWS = 64;
    localparam int RB = 6;
    localparam int WB = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [1:0]      op_i = 2'd0;
    logic [RB-1:0]   a_base = '0, b_base = '0, d_base = '0;
    logic [WB-1:0]   width_m1 = '0;
    logic            busy;
    logic            wr_en = 1'b0;
    logic [RB-1:0]   wr_row = '0;
    logic [COLS-1:0] wr_data = '0;
    logic [RB-1:0]   rd_row = '0;
    logic [COLS-1:0] rd_data;

    mbs_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .op_i(op_i),
        .a_base(a_base), .b_base(b_base), .d_base(d_base), .width_m1(width_m1),
        .busy(busy), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .rd_row(rd_row), .rd_data(rd_data)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails  = 0;
    logic [15:0] av [COLS];
    logic [15:0] bv [COLS];
    logic [15:0] rv [COLS];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_val(int l, int seed);
        return 16'((l * 40503 + seed * 7919) ^ (l * l * 131 + seed));
    endfunction

    task automatic fill(input int sa, input int sb);
        for (int l = 0; l < COLS; l++) begin
            av[l] = lane_val(l, sa);
            bv[l] = lane_val(l, sb);
        end
        av[0] = 16'hFFFF; bv[0] = 16'h0001;
        av[1] = 16'h0000; bv[1] = 16'h0000;
        av[2] = 16'hFFFF; bv[2] = 16'hFFFF;
    endtask

    task automatic write_row(input int r, input logic [COLS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = RB'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_row(input int r, output logic [COLS-1:0] d);
        @(negedge clk);
        rd_row = RB'(r);
        #1 d = rd_data;
    endtask

    task automatic load(input int base, input int w, input bit use_b);
        logic [COLS-1:0] row;
        for (int k = 0; k < w; k++) begin
            for (int l = 0; l < COLS; l++) row[l] = use_b ? bv[l][k] : av[l][k];
            write_row(base + k, row);
        end
    endtask

    task automatic gather(input int base, input int w);
        logic [COLS-1:0] row;
        for (int l = 0; l < COLS; l++) rv[l] = '0;
        for (int k = 0; k < w; k++) begin
            read_row(base + k, row);
            for (int l = 0; l < COLS; l++) rv[l][k] = row[l];
        end
    endtask

    task automatic run_op(input int op, input int a, input int b, input int d,
                          input int w, input bit inject, output int cyc);
        @(negedge clk);
        start = 1'b1; op_i = 2'(op); a_base = RB'(a); b_base = RB'(b);
        d_base = RB'(d); width_m1 = WB'(w - 1);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            if (inject && cyc == 2) begin
                start = 1'b1; op_i = 2'd2; width_m1 = 4'd15; d_base = 6'd40;
                wr_en = 1'b1; wr_row = 6'd50; wr_data = '1;
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0;
    endtask

    // kind: 0 and, 1 or, 2 add
    task automatic compare(input int kind, input int w, input logic [15:0] a_ref [COLS],
                           input string req, input string what);
        int bad = 0;
        logic [15:0] exp_first = '0, act_first = '0;
        logic [16:0] mask = (17'd1 << w) - 17'd1;
        for (int l = 0; l < COLS; l++) begin
            logic [16:0] e;
            case (kind)
                0: e = {1'b0, a_ref[l] & bv[l]};
                1: e = {1'b0, a_ref[l] | bv[l]};
                default: e = {1'b0, a_ref[l]} + {1'b0, bv[l]};
            endcase
            e = e & mask;
            if (rv[l] != e[15:0]) begin
                if (bad == 0) begin exp_first = e[15:0]; act_first = rv[l]; end
                bad++;
            end
        end
        check(bad == 0, req, what, 64'(act_first), 64'(exp_first));
    endtask

    // ---------------- scenarios ----------------

    task automatic t_reset();
        logic [COLS-1:0] d;
        check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        read_row(0, d);  check(d == '0, "R1", "row0 after reset", d, '0);
        read_row(62, d); check(d == '1, "R1", "ones row", d, '1);
        read_row(63, d); check(d == '0, "R1", "zeros row", d, '0);
    endtask

    task automatic t_host_port();
        logic [COLS-1:0] d;
        write_row(5, 64'hDEAD_BEEF_0123_4567);
        read_row(5, d);  check(d == 64'hDEAD_BEEF_0123_4567, "R2", "user row write", d, 64'hDEAD_BEEF_0123_4567);
        write_row(56, 64'h1);
        read_row(56, d); check(d == 64'h1, "R2", "last user row write", d, 64'h1);
        write_row(63, '1);
        read_row(63, d); check(d == '0, "R3", "write to zeros row", d, '0);
        write_row(62, '0);
        read_row(62, d); check(d == '1, "R3", "write to ones row", d, '1);
        write_row(57, '1);
        read_row(57, d); check(d == '0, "R3", "write to scratch row", d, '0);
    endtask

    task automatic t_and8();
        int cyc;
        fill(3, 11); load(0, 16, 1'b0); load(16, 16, 1'b1);
        run_op(0, 0, 16, 32, 8, 1'b0, cyc);
        check(cyc == 40, "R8", "AND w8 busy length", 64'(cyc), 64'd40);
        gather(32, 8); compare(0, 8, av, "R4", "AND w8 lanes");
    endtask

    task automatic t_or16();
        int cyc;
        run_op(1, 0, 16, 32, 16, 1'b0, cyc);
        check(cyc == 80, "R8", "OR w16 busy length", 64'(cyc), 64'd80);
        gather(32, 16); compare(1, 16, av, "R5", "OR w16 lanes");
    endtask

    task automatic t_add16();
        int cyc;
        run_op(2, 0, 16, 32, 16, 1'b0, cyc);
        check(cyc == 224, "R8", "ADD w16 busy length", 64'(cyc), 64'd224);
        gather(32, 16); compare(2, 16, av, "R6", "ADD w16 lanes with full carry ripple");
        gather(0, 16);
        begin
            int bad = 0;
            for (int l = 0; l < COLS; l++) if (rv[l] != av[l]) bad++;
            check(bad == 0, "R10", "operand A rows preserved", 64'(bad), 64'd0);
        end
    endtask

    task automatic t_add1();
        int cyc;
        logic [COLS-1:0] d;
        write_row(33, 64'hA5A5_5A5A_F00F_0FF0);
        run_op(2, 0, 16, 32, 1, 1'b0, cyc);
        check(cyc == 14, "R8", "ADD w1 busy length", 64'(cyc), 64'd14);
        gather(32, 1); compare(2, 1, av, "R7", "ADD w1 lanes");
        read_row(33, d);
        check(d == 64'hA5A5_5A5A_F00F_0FF0, "R7", "row above result untouched", d, 64'hA5A5_5A5A_F00F_0FF0);
    endtask

    task automatic t_inplace();
        int cyc;
        logic [15:0] a_old [COLS];
        fill(29, 71); load(0, 16, 1'b0); load(16, 16, 1'b1);
        for (int l = 0; l < COLS; l++) a_old[l] = av[l];
        run_op(2, 0, 16, 0, 12, 1'b0, cyc);
        gather(0, 12); compare(2, 12, a_old, "R11", "in-place ADD w12");
        gather(12, 4);
        begin
            int bad = 0;
            for (int l = 0; l < COLS; l++) if (rv[l][3:0] != a_old[l][15:12]) bad++;
            check(bad == 0, "R7", "A rows above w12 unchanged", 64'(bad), 64'd0);
        end
    endtask

    task automatic t_busy_guard();
        int cyc;
        logic [COLS-1:0] d;
        fill(5, 17); load(0, 16, 1'b0); load(16, 16, 1'b1);
        run_op(0, 0, 16, 32, 4, 1'b1, cyc);
        check(cyc == 20, "R9", "start during run ignored, length", 64'(cyc), 64'd20);
        gather(32, 4); compare(0, 4, av, "R9", "AND result after ignored start");
        read_row(50, d); check(d == '0, "R3", "write while busy ignored", d, '0);
        check(busy == 1'b0, "R9", "idle after guarded run", 64'(busy), 64'd0);
    endtask

    task automatic t_reserved();
        @(negedge clk);
        start = 1'b1; op_i = 2'd3; width_m1 = 4'd3;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R12", "opcode 3 rejected", 64'(busy), 64'd0);
        @(negedge clk);
        check(busy == 1'b0, "R12", "still idle", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_host_port();
        t_and8();
        t_or16();
        t_add16();
        t_add1();
        t_inplace();
        t_busy_guard();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule